// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a three-wire link to a single-channel successive-approximation converter. It drives an active-low chip select and a serial clock, and it reads the converter's serial data line. Pulling chip select low makes the converter sample and start converting. The controller then clocks one frame, with a length set by the selected resolution. It shifts the frame in MSB first, releases chip select and holds the line idle for a programmed quiet gap. Each result appears right-aligned on a data output, together with a one-cycle valid pulse.

The serial clock comes from the system clock. Each half period lasts a programmable number of system cycles. A frame carries four leading bits that the converter always sends as zero, followed by the result bits. The controller checks the leading bits and flags the frame when any of them is set. A single-shot input runs one frame. A continuous input keeps frames running back to back. The divider, quiet length and resolution are captured only when a frame is launched from idle.

Top module: `adc_serial_reader`

## Requirements
- R1: During and after reset, with no frame running, `cs_n` and `sclk` are high and `busy`, `sample_valid` and `frame_err` are low.
- R2: The serial clock rests high whenever `cs_n` is high. The first `sclk` fall of a frame comes H system cycles after `cs_n` falls, where H is `div_half`, or 1 when `div_half` is 0.
- R3: Within a frame, every low phase and every high phase of `sclk` lasts exactly H system cycles.
- R4: A frame has 16 `sclk` falls and 16 rises when `narrow_mode` is 0 (12-bit results), and 14 of each when `narrow_mode` is 1 (10-bit results).
- R5: `sdata` is sampled at each `sclk` rise and shifted in MSB first. The last 12 (or 10) bits sampled form `sample_data`, right-aligned, and the upper two bits are zero in 10-bit mode.
- R6: `cs_n` rises one system cycle after the last `sclk` rise. `sample_valid` is high for exactly that one cycle, once per frame.
- R7: The four bits sampled before the result bits are leading bits. `frame_err` is high with `sample_valid` when any leading bit is 1, and it is low at all other times.
- R8: Between the release of one frame and the launch of the next, `cs_n` stays high for `quiet_len`+2 system cycles when running continuously, and never for fewer than 2.
- R9: A `start` pulse in idle launches exactly one frame. A `start` pulse while `busy` is high has no effect.
- R10: `div_half`, `quiet_len` and `narrow_mode` are captured at launch. Changing them during a frame does not alter that frame.
- R11: While `run_cont` is high, frames are launched one after another with no `start` needed. Once it is low, the controller stops after the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-shot launch request, taken in idle |
| run_cont | input | 1 | Free-running mode enable |
| narrow_mode | input | 1 | 1 selects 10-bit results (14-clock frame), 0 selects 12-bit (16-clock frame) |
| div_half | input | DIV_W | Serial clock half period in system cycles (0 is treated as 1) |
| quiet_len | input | QUIET_W | Extra idle cycles after release before the next launch |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, rests high |
| busy | output | 1 | High from launch until the controller returns to idle |
| sample_valid | output | 1 | One-cycle pulse marking a new result |
| sample_data | output | RES_HI | Right-aligned result in straight binary |
| frame_err | output | 1 | Leading-bit error, qualified by `sample_valid` |

## Verification
The assertions assume that `start`, `run_cont` and the configuration inputs are synchronous to `clk`. They also assume that the converter changes `sdata` only after an `sclk` fall, so the value is settled at the next rise. The bench model of the converter drives each frame bit at an `sclk` fall while `cs_n` is low, and that fall always lies at least one system cycle before the rise that samples it. The bench changes all control inputs on the falling edge of `clk`. It sweeps both resolutions, half periods from 0 to 3, and data words that include all-zero, all-one and a set bit in each leading position.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_FINISH,
      ST_QUIET
   } rd_state_e;

endpackage

// File: rtl/adcrd_tick_gen.sv
// Free-running cycle counter that emits a tick every (limit+1) enabled cycles.
module adcrd_tick_gen #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] limit,
   output logic         tick
);

   logic [W-1:0] cnt;

   assign tick = en && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!en || tick)  cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/adcrd_shift_in.sv
// MSB-first capture register with result alignment and leading-bit check.
module adcrd_shift_in #(
   parameter int RES_HI    = 12,
   parameter int RES_LO    = 10,
   parameter int LEAD_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift_en,
   input  logic              din,
   input  logic              narrow,
   output logic [RES_HI-1:0] result,
   output logic              lead_bad
);

   localparam int FW = RES_HI + LEAD_BITS;

   logic [FW-1:0]        sreg;
   logic [LEAD_BITS-1:0] lead_wide;
   logic [LEAD_BITS-1:0] lead_narrow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sreg <= '0;
      else if (clear)    sreg <= '0;
      else if (shift_en) sreg <= {sreg[FW-2:0], din};
   end

   for (genvar i = 0; i < RES_HI; i++) begin : g_res
      if (i < RES_LO) begin : g_common
         assign result[i] = sreg[i];
      end else begin : g_wide_only
         assign result[i] = narrow ? 1'b0 : sreg[i];
      end
   end

   for (genvar j = 0; j < LEAD_BITS; j++) begin : g_lead
      assign lead_wide[j]   = sreg[RES_HI + j];
      assign lead_narrow[j] = sreg[RES_LO + j];
   end

   assign lead_bad = narrow ? (|lead_narrow) : (|lead_wide);

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
   import adcrd_pkg::*;
#(
   parameter int RES_HI    = 12,
   parameter int RES_LO    = 10,
   parameter int LEAD_BITS = 4,
   parameter int DIV_W     = 8,
   parameter int QUIET_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run_cont,
   input  logic              narrow_mode,
   input  logic [DIV_W-1:0]  div_half,
   input  logic [QUIET_W-1:0] quiet_len,
   input  logic              sdata,
   output logic              cs_n,
   output logic              sclk,
   output logic              busy,
   output logic              sample_valid,
   output logic [RES_HI-1:0] sample_data,
   output logic              frame_err
);

   localparam int FW    = RES_HI + LEAD_BITS;
   localparam int N_HI  = FW;
   localparam int N_LO  = RES_LO + LEAD_BITS;
   localparam int CNT_W = $clog2(FW + 1);

   if (RES_LO < 1 || RES_LO >= RES_HI) begin : g_bad_res
      $error("adc_serial_reader: RES_LO must be in 1..RES_HI-1");
   end
   if (LEAD_BITS < 1) begin : g_bad_lead
      $error("adc_serial_reader: LEAD_BITS must be at least 1");
   end
   if (DIV_W < 1 || QUIET_W < 1) begin : g_bad_cnt
      $error("adc_serial_reader: counter widths must be positive");
   end

   rd_state_e          state;
   logic [DIV_W-1:0]   div_lat;
   logic [QUIET_W-1:0] quiet_lat;
   logic               narrow_lat;
   logic [CNT_W-1:0]   bitcnt;
   logic [CNT_W-1:0]   last_idx;
   logic               cs_n_q, sclk_q, valid_q, err_q;
   logic [RES_HI-1:0]  data_q;

   logic               half_en, half_tick;
   logic               gap_en, gap_tick;
   logic               rise_now;
   logic [RES_HI-1:0]  cap_result;
   logic               cap_lead_bad;

   assign last_idx = narrow_lat ? CNT_W'(N_LO - 1) : CNT_W'(N_HI - 1);
   assign half_en  = (state == ST_LEAD) || (state == ST_SHIFT);
   assign gap_en   = (state == ST_QUIET);
   assign rise_now = (state == ST_SHIFT) && half_tick && !sclk_q;

   adcrd_tick_gen #(.W(DIV_W)) i_half_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (half_en),
      .limit (div_lat - 1'b1),
      .tick  (half_tick)
   );

   adcrd_tick_gen #(.W(QUIET_W)) i_gap_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (gap_en),
      .limit (quiet_lat),
      .tick  (gap_tick)
   );

   adcrd_shift_in #(
      .RES_HI    (RES_HI),
      .RES_LO    (RES_LO),
      .LEAD_BITS (LEAD_BITS)
   ) i_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (state == ST_IDLE),
      .shift_en (rise_now),
      .din      (sdata),
      .narrow   (narrow_lat),
      .result   (cap_result),
      .lead_bad (cap_lead_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         div_lat    <= DIV_W'(1);
         quiet_lat  <= '0;
         narrow_lat <= 1'b0;
         bitcnt     <= '0;
         cs_n_q     <= 1'b1;
         sclk_q     <= 1'b1;
         valid_q    <= 1'b0;
         err_q      <= 1'b0;
         data_q     <= '0;
      end else begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start || run_cont) begin
                  state      <= ST_LEAD;
                  cs_n_q     <= 1'b0;
                  div_lat    <= (div_half == '0) ? DIV_W'(1) : div_half;
                  quiet_lat  <= quiet_len;
                  narrow_lat <= narrow_mode;
                  bitcnt     <= '0;
               end
            end
            ST_LEAD: begin
               if (half_tick) begin
                  state  <= ST_SHIFT;
                  sclk_q <= 1'b0;
               end
            end
            ST_SHIFT: begin
               if (half_tick) begin
                  sclk_q <= ~sclk_q;
                  if (!sclk_q) begin
                     if (bitcnt == last_idx) state  <= ST_FINISH;
                     else                    bitcnt <= bitcnt + 1'b1;
                  end
               end
            end
            ST_FINISH: begin
               state   <= ST_QUIET;
               cs_n_q  <= 1'b1;
               valid_q <= 1'b1;
               data_q  <= cap_result;
               err_q   <= cap_lead_bad;
            end
            ST_QUIET: begin
               if (gap_tick) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cs_n         = cs_n_q;
   assign sclk         = sclk_q;
   assign busy         = (state != ST_IDLE);
   assign sample_valid = valid_q;
   assign sample_data  = data_q;
   assign frame_err    = err_q;

endmodule

// File: rtl/adcrd_checker.sv
module adcrd_checker (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic busy,
   input logic sample_valid,
   input logic frame_err
);

   logic [3:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hi_cnt <= 4'hF;
      else if (!cs_n)            hi_cnt <= '0;
      else if (hi_cnt != 4'hF)   hi_cnt <= hi_cnt + 1'b1;
   end

   p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n && sclk));

   p_sclk_rests_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   p_sclk_only_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk) |-> !cs_n);

   p_release_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> $rose(cs_n));

   p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid);

   p_err_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> sample_valid);

   p_gap_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (hi_cnt >= 4'd2));

   p_low_means_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

endmodule

bind adc_serial_reader adcrd_checker i_adcrd_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_n         (cs_n),
   .sclk         (sclk),
   .busy         (busy),
   .sample_valid (sample_valid),
   .frame_err    (frame_err)
);

// File: tb/test_adc_serial_reader.sv
`timescale 1ns/1ps
module test_adc_serial_reader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        run_cont = 1'b0;
   logic        narrow_mode = 1'b0;
   logic [7:0]  div_half = 8'd1;
   logic [7:0]  quiet_len = 8'd0;
   logic        sdata = 1'b0;
   logic        cs_n, sclk, busy, sample_valid, frame_err;
   logic [11:0] sample_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [15:0] dev_word = '0;
   int          dev_n = 16;
   int          dev_idx = 0;

   always #2.5 clk = ~clk;

   adc_serial_reader i_adc_serial_reader (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .run_cont     (run_cont),
      .narrow_mode  (narrow_mode),
      .div_half     (div_half),
      .quiet_len    (quiet_len),
      .sdata        (sdata),
      .cs_n         (cs_n),
      .sclk         (sclk),
      .busy         (busy),
      .sample_valid (sample_valid),
      .sample_data  (sample_data),
      .frame_err    (frame_err)
   );

   // converter model: next frame bit appears after each sclk fall
   always @(negedge sclk or posedge cs_n) begin
      if (cs_n) dev_idx = 0;
      else if (dev_idx < dev_n) begin
         sdata = dev_word[dev_n - 1 - dev_idx];
         dev_idx = dev_idx + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic run_frame(input bit mode, input int div, input logic [3:0] lead,
                            input logic [11:0] dat, input bit perturb, input bit extra_start);
      int h = (div == 0) ? 1 : div;
      int n = mode ? 14 : 16;
      logic [11:0] exp_d = mode ? {2'b00, dat[9:0]} : dat;
      int t = 0, t_cs = -1000, t_last = -1000, first_gap = -1;
      int rises = 0, falls = 0, cs_falls = 0, valids = 0, t_valid = -1;
      bit phase_ok = 1, rel_ok = 1, prev_cs = 1, prev_sclk = 1;
      logic [11:0] got_d = '0;
      bit got_e = 0;
      dev_word = mode ? {2'b00, lead, dat[9:0]} : {lead, dat};
      dev_n = n;
      narrow_mode = mode;
      div_half = 8'(div);
      quiet_len = 8'd1;
      @(negedge clk);
      start = 1'b1;
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         start = 1'b0;
         t++;
         if (prev_cs && !cs_n) begin
            cs_falls++; t_cs = t; t_last = t;
         end
         if (sclk != prev_sclk) begin
            if (!sclk && falls == 0) first_gap = t - t_cs;
            else if (t - t_last != h) phase_ok = 0;
            t_last = t;
            if (!sclk) falls++; else rises++;
         end
         if (sample_valid) begin
            valids++; t_valid = t;
            got_d = sample_data; got_e = frame_err;
            if (!(cs_n && t_last == t - 1)) rel_ok = 0;
         end else if (frame_err) rel_ok = 0;
         if (perturb && t == t_cs + 3) begin
            narrow_mode = ~mode; div_half = 8'(div + 1);
         end
         if (extra_start && t == t_cs + 5) start = 1'b1;
         prev_cs = cs_n; prev_sclk = sclk;
         if (t_valid >= 0 && t > t_valid + 40) break;
      end
      start = 1'b0;
      check(first_gap == h, "R2", "cs fall to first sclk fall", first_gap, h);
      check(phase_ok, "R3", "sclk phase lengths", phase_ok, 1);
      check(rises == n && falls == n, "R4", "sclk rises in frame", rises, n);
      check(got_d == exp_d, "R5", "sample_data", got_d, exp_d);
      check(valids == 1 && rel_ok, "R6", "valid pulses and release", valids, 1);
      check(got_e == (lead != 0), "R7", "frame_err", got_e, (lead != 0));
      if (extra_start) check(cs_falls == 1, "R9", "frames for one start", cs_falls, 1);
      if (perturb) check(rises == n && phase_ok && got_d == exp_d, "R10",
                         "frame unaffected by late config", rises, n);
   endtask

   task automatic run_cont_test(input int q, input int frames);
      int t = 0, t_rise = -1, vcount = 0, cs_falls = 0;
      bit prev_cs = 1, gap_ok = 1, data_ok = 1;
      int bad_gap = 0;
      dev_word = {4'h0, 12'h6B1};
      dev_n = 16;
      narrow_mode = 1'b0;
      div_half = 8'd1;
      quiet_len = 8'(q);
      @(negedge clk);
      run_cont = 1'b1;
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         t++;
         if (!prev_cs && cs_n) t_rise = t;
         if (prev_cs && !cs_n) begin
            cs_falls++;
            if (t_rise >= 0 && t - t_rise != q + 2) begin
               gap_ok = 0; bad_gap = t - t_rise;
            end
         end
         if (sample_valid) begin
            vcount++;
            if (sample_data != 12'h6B1) data_ok = 0;
            if (vcount == frames) run_cont = 1'b0;
         end
         prev_cs = cs_n;
         if (vcount == frames && !busy && t > t_rise + q + 10) break;
      end
      run_cont = 1'b0;
      check(gap_ok, "R8", "release to relaunch gap", bad_gap, q + 2);
      check(vcount == frames && cs_falls == frames, "R11", "continuous frame count",
            cs_falls, frames);
      check(data_ok, "R5", "continuous data", data_ok, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n === 1'b1 && sclk === 1'b1, "R1", "lines in reset", {cs_n, sclk}, 3);
      check(sample_valid === 1'b0 && busy === 1'b0 && frame_err === 1'b0, "R1",
            "flags in reset", {busy, sample_valid, frame_err}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(cs_n && sclk && !busy && !sample_valid, "R1", "idle after reset",
            {cs_n, sclk, busy, sample_valid}, 12);

      for (int m = 0; m < 2; m++) begin
         for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 4; p++) begin
               logic [3:0]  ld = 4'h0;
               logic [11:0] dt = 12'h000;
               case (p)
                  0: dt = 12'h000;
                  1: dt = 12'hFFF;
                  2: dt = 12'hA5C ^ 12'(d * 12'h111);
                  default: begin ld = 4'(1 << d); dt = 12'h3C3; end
               endcase
               run_frame(m[0], d, ld, dt, 1'b0, 1'b0);
            end
         end
      end

      run_frame(1'b0, 2, 4'h0, 12'h9E7, 1'b1, 1'b0);
      run_frame(1'b1, 1, 4'h0, 12'h2D4, 1'b1, 1'b0);
      run_frame(1'b0, 1, 4'h0, 12'h571, 1'b0, 1'b1);

      run_cont_test(0, 3);
      run_cont_test(3, 3);
      run_cont_test(5, 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule